// File: doc/BRIEF.md
# Interrupt Priority and Acknowledge Unit

This unit is the core of an eight-line interrupt controller. It keeps three eight-bit state words: the pending requests, the lines currently in service, and a mask supplied by the command sequencer. It watches the request pins for rising transitions, decides when a new request may interrupt the processor, and raises a single interrupt output. When the processor acknowledges, it picks the winning line, moves it from pending to in service, and returns an eight-bit vector. If that line has a cascaded slave controller behind it, it also raises a slave-select indication.

Priority is fixed: a higher line number always wins. A request on line n reaches the processor only while no line from n up to 7 is in service. End-of-interrupt commands from the sequencer retire the in-service line, either named explicitly or taken as the highest one in service. After any end-of-interrupt, a request that had been held back is offered again. An automatic end-of-interrupt setting leaves the in-service word untouched on acknowledge. Rotating priority is not supported.

Top module: `intr_prio_ack`

## Requirements
- R1: After reset `int_out`, `vec_valid` and `slave_sel` are low and the pending and in-service words are empty.
- R2: A request is recorded only on a low-to-high change of a pin; a pin that stays high records nothing further.
- R3: A rising pin whose bit in `cfg_mask` is 1 is discarded and leaves no pending request.
- R4: A new request on line n raises `int_out` on the clock edge that samples the rise, but only when in-service bits n through 7 are all clear.
- R5: On acknowledge the winner is the highest-numbered pending line.
- R6: `vec_valid` pulses for one cycle on the edge after `ack` is sampled, and `vec_out` is `{cfg_base, line}` with the line number in bits 2:0 and `cfg_base` in bits 7:3.
- R7: `slave_sel` goes high with the vector when the winning line's bit in `cfg_cascade` is 1 and `cfg_slave_present` is 1; otherwise it stays low.
- R8: On acknowledge the winner's pending bit clears and its in-service bit sets.
- R9: With `cfg_auto_eoi` at 1 an acknowledge leaves the in-service word unchanged.
- R10: An acknowledge with no pending request returns `{cfg_base, 3'b111}` with `slave_sel` low and changes no state.
- R11: `eoi_spec` clears the in-service bit of `eoi_line`; `eoi_nonspec` clears only the highest set in-service bit. If both are high, the specific form applies.
- R12: After either end-of-interrupt, if requests are pending and the highest one is no longer blocked by in-service bits at or above it, `int_out` rises on that same edge.
- R13: Once high, `int_out` stays high until an acknowledge is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pin | input | 8 | Request pins, one per line |
| cfg_mask | input | 8 | Per-line mask, 1 discards that line's requests |
| cfg_cascade | input | 8 | Lines that have a slave controller behind them |
| cfg_base | input | 5 | Upper five bits of the returned vector |
| cfg_auto_eoi | input | 1 | Acknowledge does not set in-service |
| cfg_slave_present | input | 1 | A slave controller is attached |
| ack | input | 1 | Processor acknowledge strobe, one cycle |
| eoi_nonspec | input | 1 | Retire the highest in-service line |
| eoi_spec | input | 1 | Retire the line named by `eoi_line` |
| eoi_line | input | 3 | Line for a specific end-of-interrupt |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | One-cycle strobe marking `vec_out` valid |
| slave_sel | output | 1 | The slave must supply the vector |
| vec_out | output | 8 | Interrupt vector |

## Verification
On every cycle the assertions check that the interrupt output holds until an acknowledge, that a masked rise never creates a pending bit, that an empty acknowledge returns the top vector without touching state, that automatic end-of-interrupt leaves the in-service word alone, and that slave select never appears without a slave present. Priority order, gating of lower lines by an in-service line, which bit each end-of-interrupt form retires, re-offering of a held request, and cascade vectors can only be shown by the bench's sequences, which infer the hidden in-service and pending words from later interrupt and vector behaviour.

// File: rtl/intr_prio_ack.sv
module intr_prio_ack (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_pin,
  input  logic [7:0] cfg_mask,
  input  logic [7:0] cfg_cascade,
  input  logic [4:0] cfg_base,
  input  logic       cfg_auto_eoi,
  input  logic       cfg_slave_present,
  input  logic       ack,
  input  logic       eoi_nonspec,
  input  logic       eoi_spec,
  input  logic [2:0] eoi_line,
  output logic       int_out,
  output logic       vec_valid,
  output logic       slave_sel,
  output logic [7:0] vec_out
);

  function automatic logic [2:0] top_bit(input logic [7:0] v);
    logic [2:0] r;
    r = 3'd0;
    for (int i = 0; i < 8; i++)
      if (v[i]) r = 3'(i);
    return r;
  endfunction

  logic [7:0] pin_q, pend_q, serv_q;
  logic       int_q;

  logic [7:0] fresh;
  logic [2:0] win;
  logic       has_req, take;
  logic [7:0] win_oh, retire, pend_left, serv_left;
  logic       any_eoi, fwd_new, reoffer;

  assign fresh   = irq_pin & ~pin_q & ~cfg_mask;
  assign win     = top_bit(pend_q);
  assign has_req = |pend_q;
  assign take    = ack & has_req;
  assign win_oh  = take ? (8'b1 << win) : 8'b0;
  assign any_eoi = eoi_spec | eoi_nonspec;

  always_comb begin
    if (eoi_spec)
      retire = 8'b1 << eoi_line;
    else if (eoi_nonspec && |serv_q)
      retire = 8'b1 << top_bit(serv_q);
    else
      retire = 8'b0;
  end

  assign pend_left = pend_q & ~win_oh;
  assign serv_left = serv_q & ~retire;

  always_comb begin
    fwd_new = 1'b0;
    for (int i = 0; i < 8; i++)
      if (fresh[i] && ((serv_q >> i) == 8'b0)) fwd_new = 1'b1;
  end

  assign reoffer = any_eoi && (|pend_left) &&
                   ((serv_left >> top_bit(pend_left)) == 8'b0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q     <= 8'b0;
      pend_q    <= 8'b0;
      serv_q    <= 8'b0;
      int_q     <= 1'b0;
      vec_valid <= 1'b0;
      slave_sel <= 1'b0;
      vec_out   <= 8'b0;
    end else begin
      pin_q     <= irq_pin;
      pend_q    <= pend_left | fresh;
      serv_q    <= serv_left | (cfg_auto_eoi ? 8'b0 : win_oh);
      int_q     <= (int_q & ~ack) | fwd_new | reoffer;
      vec_valid <= ack;
      if (ack) begin
        vec_out   <= {cfg_base, has_req ? win : 3'd7};
        slave_sel <= take & cfg_cascade[win] & cfg_slave_present;
      end else begin
        slave_sel <= 1'b0;
      end
    end
  end

  assign int_out = int_q;

  // R13
  int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out && !ack |=> int_out);

  // R3
  mask_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & $past(cfg_mask)) == 8'b0));

  // R10
  empty_ack_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack && pend_q == 8'b0 && !any_eoi |=>
      vec_out == {$past(cfg_base), 3'b111} && !slave_sel && $stable(serv_q));

  // R9
  auto_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack && cfg_auto_eoi && !any_eoi |=> $stable(serv_q));

  // R7
  slave_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slave_sel |-> $past(cfg_slave_present) && vec_valid);

endmodule

// File: tb/sim_intr_prio_ack.sv
module sim_intr_prio_ack;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] irq_pin = 0, cfg_mask = 0, cfg_cascade = 8'b0000_0100;
  logic [4:0] cfg_base = 5'h0A;
  logic       cfg_auto_eoi = 0, cfg_slave_present = 1;
  logic       ack = 0, eoi_nonspec = 0, eoi_spec = 0;
  logic [2:0] eoi_line = 0;
  logic       int_out, vec_valid, slave_sel;
  logic [7:0] vec_out;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [8:0] expq[$];
  string      tagq[$];

  always #2 clk = ~clk;

  intr_prio_ack u0 (.*);

  task automatic chk(input string tag, input logic [8:0] got, input logic [8:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_ack(input string tag, input logic [7:0] vec, input logic ss);
    @(negedge clk);
    ack = 1;
    expq.push_back({ss, vec});
    tagq.push_back(tag);
    @(negedge clk);
    ack = 0;
  endtask

  task automatic raise(input int n);
    @(negedge clk);
    irq_pin[n] = 1;
    @(negedge clk);
  endtask

  task automatic drop_all;
    @(negedge clk);
    irq_pin = 0;
    @(negedge clk);
  endtask

  task automatic eoi_n;
    @(negedge clk);
    eoi_nonspec = 1;
    @(negedge clk);
    eoi_nonspec = 0;
  endtask

  task automatic eoi_s(input logic [2:0] l);
    @(negedge clk);
    eoi_spec = 1;
    eoi_line = l;
    @(negedge clk);
    eoi_spec = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      if (expq.size() == 0) begin
        tests++;
        fails++;
        $display("FAIL R6: vector %h with nothing expected", vec_out);
      end else begin
        string t;
        logic [8:0] e;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(t, {slave_sel, vec_out}, e);
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 int", {8'b0, int_out}, 9'd0);
    chk("R1 valid/slave", {7'b0, vec_valid, slave_sel}, 9'd0);
    do_ack("R1 R10 empty ack", 8'h57, 0);
    chk("R10 int", {8'b0, int_out}, 9'd0);

    raise(3);
    chk("R4 line3 int", {8'b0, int_out}, 9'd1);
    repeat (3) @(negedge clk);
    chk("R13 hold", {8'b0, int_out}, 9'd1);
    do_ack("R6 R8 line3", 8'h53, 0);
    chk("R13 cleared by ack", {8'b0, int_out}, 9'd0);

    raise(1);
    chk("R4 R8 line1 gated", {8'b0, int_out}, 9'd0);
    eoi_s(3'd3);
    chk("R11 R12 reoffer after specific", {8'b0, int_out}, 9'd1);
    do_ack("R12 line1", 8'h51, 0);
    eoi_n();
    chk("R11 no pending", {8'b0, int_out}, 9'd0);
    repeat (2) @(negedge clk);
    chk("R2 held pins", {8'b0, int_out}, 9'd0);
    do_ack("R2 R8 empty after held", 8'h57, 0);
    drop_all();

    cfg_mask = 8'h20;
    raise(5);
    chk("R3 masked int", {8'b0, int_out}, 9'd0);
    do_ack("R3 masked no pending", 8'h57, 0);
    cfg_mask = 0;
    drop_all();

    @(negedge clk);
    irq_pin[1] = 1;
    irq_pin[6] = 1;
    @(negedge clk);
    chk("R4 two lines", {8'b0, int_out}, 9'd1);
    do_ack("R5 winner 6", 8'h56, 0);
    chk("R4 line1 behind 6", {8'b0, int_out}, 9'd0);
    eoi_n();
    chk("R12 reoffer line1", {8'b0, int_out}, 9'd1);
    do_ack("R5 then 1", 8'h51, 0);
    eoi_n();
    drop_all();

    raise(2);
    do_ack("R7 cascade slave", 8'h52, 1);
    eoi_n();
    drop_all();
    cfg_slave_present = 0;
    raise(2);
    do_ack("R7 no slave present", 8'h52, 0);
    eoi_n();
    drop_all();

    cfg_auto_eoi = 1;
    raise(4);
    do_ack("R9 auto line4", 8'h54, 0);
    raise(2);
    chk("R9 lower not blocked", {8'b0, int_out}, 9'd1);
    do_ack("R9 auto line2", 8'h52, 0);
    cfg_auto_eoi = 0;
    drop_all();

    raise(4);
    do_ack("R8 line4", 8'h54, 0);
    raise(6);
    chk("R4 higher preempts", {8'b0, int_out}, 9'd1);
    do_ack("R8 line6", 8'h56, 0);
    eoi_n();
    raise(5);
    chk("R11 nonspec cleared top only", {8'b0, int_out}, 9'd1);
    do_ack("R11 line5", 8'h55, 0);
    raise(3);
    chk("R4 line3 blocked", {8'b0, int_out}, 9'd0);
    eoi_n();
    chk("R11 line4 still in service", {8'b0, int_out}, 9'd0);
    eoi_n();
    chk("R12 reoffer line3", {8'b0, int_out}, 9'd1);
    do_ack("R12 line3", 8'h53, 0);
    eoi_n();
    drop_all();

    repeat (2) @(negedge clk);
    chk("R6 all vectors seen", {1'b0, 8'(expq.size())}, 9'd0);
    finish_run();
  end
endmodule